// File: doc/BRIEF.md
# External Bus Strobe Decoder

This block drives the address-latch and chip-select strobes of an external host bus. A 4-bit configuration code decides which of five shared output pins (A to E, indices 0 to 4) carries an address-latch pulse, which pins carry active-low chip selects, and which pins are unused. At every cycle start it takes the hit flags for the three mapped regions (code, peripheral, memory), the region size fields and the upper address bits. From these it picks the one chip select to assert, and it holds that select until the cycle ends.

In the two-select codes the choice depends on which regions are enabled. If only one region is enabled, both selects share that range and the top address bit divides it. If two regions are enabled, each region gets its own select. In the four-select codes the two top address bits choose the select. A code that is reserved or that has the extension bit set switches every pin off and sets an error flag that stays set until reset.

Top module: `xbus_strobe_gen`

## Requirements
- R1: After reset the code is 0x0 and `cfg_err` is 0. Only pin A is enabled (`pin_oe` = 5'b00001), and `pin_out` = 0.
- R2: Pin roles by code, with bit 0 as pin A. 0x0: A=ALE. 0x1: A=CS0. 0x2: A=CS0, B=CS1. 0x3: A=ALE, B=CS1, C=CS0. 0x4: A=ALE, B=CS0. 0x5: A=CS0, B=CS1, D=CS2, E=CS3. 0x6: A=ALE, B=CS1, C=CS0, D=CS2, E=CS3. A pin that has a role has `pin_oe` = 1. A pin with no role has `pin_oe` = 0 and `pin_out` = 0.
- R3: In codes 0x0, 0x3, 0x4 and 0x6 the ALE pin goes high for exactly the one clock that follows the edge at which `cyc_start` is sampled. At all other times it is low.
- R4: Chip-select pins are high when idle. The selected pin goes low on the edge that samples `cyc_start` and returns high on the edge that samples `cyc_end`. At most one chip select is low at any time.
- R5: Single-select codes (0x1 and 0x4) assert CS0 for an access that hits any region whose field is nonzero.
- R6: Two-select codes (0x2 and 0x3) may have exactly one of peripheral or memory nonzero, with the code field zero. Then an access that hits that region asserts CS0 when `addr_hi[1]` = 0 and CS1 when `addr_hi[1]` = 1.
- R7: Two-select codes with peripheral and memory both nonzero and the code field zero: a peripheral hit asserts CS0 and a memory hit asserts CS1.
- R8: Two-select codes with the code field equal to 1 and exactly one of peripheral or memory nonzero: a code hit asserts CS0, and a hit on the enabled other region asserts CS1.
- R9: Four-select codes (0x5 and 0x6): an access that hits an enabled region asserts CS number `addr_hi` (0 to 3).
- R10: An access that hits no enabled region, or any region combination not listed in R6 to R8, asserts no chip select.
- R11: Code 0x7, or any code with bit 3 set, gives `pin_oe` = 0 and `pin_out` = 0 and sets `cfg_err`. `cfg_err` then stays 1 until reset, even after a valid code is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 4 | Strobe configuration code; bit 3 is the extension bit |
| rgn_code | input | REGION_W | Code region field (0 = disabled) |
| rgn_periph | input | REGION_W | Peripheral region field (0 = disabled) |
| rgn_mem | input | REGION_W | Memory region field (0 = disabled) |
| hit_code | input | 1 | Access falls in the code region |
| hit_periph | input | 1 | Access falls in the peripheral region |
| hit_mem | input | 1 | Access falls in the memory region |
| addr_hi | input | 2 | Two most significant bits of the active range |
| cyc_start | input | 1 | Bus cycle start strobe |
| cyc_end | input | 1 | Bus cycle end strobe |
| pin_out | output | 5 | Pin values A..E (bit 0 = A) |
| pin_oe | output | 5 | Pin output enables |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
The bench builds the block with REGION_W = 3. This allows a code field of 2, which is nonzero but not 1, and so exercises the rule that only the value 1 lets the code region share the selects. Every configuration code from 0x0 to 0x6 runs a complete start-hold-end access. Each run checks the output value in the ALE clock, in the hold clock and after release. The reserved code and one extended code are applied, and the bench checks that the error flag stays set after a valid code is restored and that a new reset clears it.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

    localparam int NUM_PINS = 5;
    localparam int NUM_CS   = 4;
    localparam int CS_IDX_W = $clog2(NUM_CS);
    localparam int MODE_W   = 4;

    typedef enum logic [2:0] {
        ROLE_NONE = 3'd0,
        ROLE_ALE  = 3'd1,
        ROLE_CS0  = 3'd2,
        ROLE_CS1  = 3'd3,
        ROLE_CS2  = 3'd4,
        ROLE_CS3  = 3'd5
    } pin_role_e;

    typedef struct packed {
        logic [MODE_W-1:0]   mode;
        logic                ale;
        logic                active;
        logic [CS_IDX_W-1:0] cs_idx;
        logic                err;
    } strobe_state_t;

    function automatic logic mode_legal(input logic [MODE_W-1:0] m);
        return (m[3] == 1'b0) && (m[2:0] != 3'd7);
    endfunction

    function automatic logic mode_has_ale(input logic [MODE_W-1:0] m);
        return (m == 4'd0) || (m == 4'd3) || (m == 4'd4) || (m == 4'd6);
    endfunction

endpackage

// File: rtl/xbs_role_map.sv
module xbs_role_map
    import xbs_pkg::*;
(
    input  logic [MODE_W-1:0]          mode,
    output pin_role_e [NUM_PINS-1:0]   roles
);
    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) roles[i] = ROLE_NONE;
        case (mode)
            4'd0: roles[0] = ROLE_ALE;
            4'd1: roles[0] = ROLE_CS0;
            4'd2: begin
                roles[0] = ROLE_CS0;
                roles[1] = ROLE_CS1;
            end
            4'd3: begin
                roles[0] = ROLE_ALE;
                roles[1] = ROLE_CS1;
                roles[2] = ROLE_CS0;
            end
            4'd4: begin
                roles[0] = ROLE_ALE;
                roles[1] = ROLE_CS0;
            end
            4'd5: begin
                roles[0] = ROLE_CS0;
                roles[1] = ROLE_CS1;
                roles[3] = ROLE_CS2;
                roles[4] = ROLE_CS3;
            end
            4'd6: begin
                roles[0] = ROLE_ALE;
                roles[1] = ROLE_CS1;
                roles[2] = ROLE_CS0;
                roles[3] = ROLE_CS2;
                roles[4] = ROLE_CS3;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xbs_cs_select.sv
module xbs_cs_select
    import xbs_pkg::*;
#(
    parameter int REGION_W = 4
) (
    input  logic [MODE_W-1:0]   mode,
    input  logic [REGION_W-1:0] rgn_code,
    input  logic [REGION_W-1:0] rgn_periph,
    input  logic [REGION_W-1:0] rgn_mem,
    input  logic                hit_code,
    input  logic                hit_periph,
    input  logic                hit_mem,
    input  logic [1:0]          addr_hi,
    output logic                sel_valid,
    output logic [CS_IDX_W-1:0] sel_idx
);
    localparam logic [REGION_W-1:0] CODE_SHARE = REGION_W'(1);

    logic en_c, en_p, en_m;
    logic any_hit;
    logic is_single, is_dual, is_quad;

    assign en_c = (rgn_code   != '0);
    assign en_p = (rgn_periph != '0);
    assign en_m = (rgn_mem    != '0);
    assign any_hit = (hit_code & en_c) | (hit_periph & en_p) | (hit_mem & en_m);

    assign is_single = (mode == 4'd1) || (mode == 4'd4);
    assign is_dual   = (mode == 4'd2) || (mode == 4'd3);
    assign is_quad   = (mode == 4'd5) || (mode == 4'd6);

    always_comb begin
        sel_valid = 1'b0;
        sel_idx   = '0;
        if (is_single) begin
            sel_valid = any_hit;
        end else if (is_quad) begin
            sel_valid = any_hit;
            sel_idx   = CS_IDX_W'(addr_hi);
        end else if (is_dual) begin
            if (!en_c && (en_p ^ en_m)) begin
                // one shared range split by top address bit
                sel_valid = en_p ? hit_periph : hit_mem;
                sel_idx   = CS_IDX_W'(addr_hi[1]);
            end else if (!en_c && en_p && en_m) begin
                if (hit_periph) begin
                    sel_valid = 1'b1;
                    sel_idx   = CS_IDX_W'(0);
                end else if (hit_mem) begin
                    sel_valid = 1'b1;
                    sel_idx   = CS_IDX_W'(1);
                end
            end else if ((rgn_code == CODE_SHARE) && (en_p ^ en_m)) begin
                if (hit_code) begin
                    sel_valid = 1'b1;
                    sel_idx   = CS_IDX_W'(0);
                end else if ((hit_periph && en_p) || (hit_mem && en_m)) begin
                    sel_valid = 1'b1;
                    sel_idx   = CS_IDX_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/xbs_pin_drive.sv
module xbs_pin_drive
    import xbs_pkg::*;
(
    input  pin_role_e [NUM_PINS-1:0] roles,
    input  logic                     ale,
    input  logic [NUM_CS-1:0]        cs_low,
    output logic [NUM_PINS-1:0]      pin_out,
    output logic [NUM_PINS-1:0]      pin_oe
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        always_comb begin
            pin_oe[p]  = (roles[p] != ROLE_NONE);
            case (roles[p])
                ROLE_ALE: pin_out[p] = ale;
                ROLE_CS0: pin_out[p] = ~cs_low[0];
                ROLE_CS1: pin_out[p] = ~cs_low[1];
                ROLE_CS2: pin_out[p] = ~cs_low[2];
                ROLE_CS3: pin_out[p] = ~cs_low[3];
                default:  pin_out[p] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbs_pkg::*;
#(
    parameter int REGION_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          cfg_mode,
    input  logic [REGION_W-1:0] rgn_code,
    input  logic [REGION_W-1:0] rgn_periph,
    input  logic [REGION_W-1:0] rgn_mem,
    input  logic                hit_code,
    input  logic                hit_periph,
    input  logic                hit_mem,
    input  logic [1:0]          addr_hi,
    input  logic                cyc_start,
    input  logic                cyc_end,
    output logic [4:0]          pin_out,
    output logic [4:0]          pin_oe,
    output logic                cfg_err
);
    strobe_state_t st_d, st_q;
    logic                 sel_valid;
    logic [CS_IDX_W-1:0]  sel_idx;
    pin_role_e [NUM_PINS-1:0] roles;
    logic [NUM_CS-1:0]    cs_low;

    xbs_cs_select #(.REGION_W(REGION_W)) u_sel (
        .mode       (cfg_mode),
        .rgn_code   (rgn_code),
        .rgn_periph (rgn_periph),
        .rgn_mem    (rgn_mem),
        .hit_code   (hit_code),
        .hit_periph (hit_periph),
        .hit_mem    (hit_mem),
        .addr_hi    (addr_hi),
        .sel_valid  (sel_valid),
        .sel_idx    (sel_idx)
    );

    always_comb begin
        st_d     = st_q;
        st_d.mode = cfg_mode;
        st_d.ale = 1'b0;
        if (cyc_end) st_d.active = 1'b0;
        if (!mode_legal(cfg_mode)) begin
            st_d.err    = 1'b1;
            st_d.active = 1'b0;
        end else if (cyc_start) begin
            st_d.ale    = mode_has_ale(cfg_mode);
            st_d.active = sel_valid;
            st_d.cs_idx = sel_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    xbs_role_map u_roles (
        .mode  (st_q.mode),
        .roles (roles)
    );

    for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
        assign cs_low[k] = st_q.active && (st_q.cs_idx == CS_IDX_W'(k));
    end

    xbs_pin_drive u_drive (
        .roles   (roles),
        .ale     (st_q.ale),
        .cs_low  (cs_low),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    assign cfg_err = st_q.err;
endmodule

// File: rtl/xbs_checker.sv
module xbs_checker
    import xbs_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cyc_start,
    input logic                     cyc_end,
    input logic [3:0]               mode_q,
    input pin_role_e [NUM_PINS-1:0] roles,
    input logic [4:0]               pin_out,
    input logic [4:0]               pin_oe,
    input logic                     cfg_err
);
    logic [4:0] ale_mask, cs_mask;
    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            ale_mask[i] = (roles[i] == ROLE_ALE);
            cs_mask[i]  = (roles[i] != ROLE_ALE) && (roles[i] != ROLE_NONE);
        end
    end

    // R3
    ale_single_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ale_mask) != 0) |=> ((pin_out & ale_mask) == 0));

    // R3
    ale_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ale_mask) != 0) |-> $past(cyc_start));

    // R4
    one_cs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cs_mask & pin_oe & ~pin_out) <= 1);

    // R4
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_end && !cyc_start) |=> ((cs_mask & ~pin_out) == 0));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R11
    bad_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[3] || mode_q[2:0] == 3'd7) |-> (pin_oe == 5'b0 && pin_out == 5'b0 && cfg_err));

    // R2
    unused_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == 5'b0);
endmodule

bind xbus_strobe_gen xbs_checker u_xbs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .cyc_end   (cyc_end),
    .mode_q    (st_q.mode),
    .roles     (roles),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .cfg_err   (cfg_err)
);

// File: tb/xbus_strobe_gen_bench.sv
module xbus_strobe_gen_bench;
    localparam int RW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] cfg_mode = 4'd0;
    logic [RW-1:0] rgn_code = '0, rgn_periph = '0, rgn_mem = '0;
    logic hit_code = 1'b0, hit_periph = 1'b0, hit_mem = 1'b0;
    logic [1:0] addr_hi = 2'b00;
    logic cyc_start = 1'b0, cyc_end = 1'b0;
    logic [4:0] pin_out, pin_oe;
    logic cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xbus_strobe_gen #(.REGION_W(RW)) u_xbus_strobe_gen (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .rgn_code(rgn_code), .rgn_periph(rgn_periph), .rgn_mem(rgn_mem),
        .hit_code(hit_code), .hit_periph(hit_periph), .hit_mem(hit_mem),
        .addr_hi(addr_hi), .cyc_start(cyc_start), .cyc_end(cyc_end),
        .pin_out(pin_out), .pin_oe(pin_oe), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic [3:0] m, input logic [RW-1:0] c, p, r);
        cfg_mode = m; rgn_code = c; rgn_periph = p; rgn_mem = r;
        @(negedge clk);
    endtask

    task automatic set_hit(input logic hc, hp, hm, input logic [1:0] ah);
        hit_code = hc; hit_periph = hp; hit_mem = hm; addr_hi = ah;
    endtask

    // one access: idle value, ALE clock, hold clock, value after end
    task automatic access(input string tag, input logic [4:0] oe,
                          input logic [4:0] first, hold, idle);
        chk({tag, " oe"}, pin_oe, oe);
        chk({tag, " idle-before"}, pin_out, idle);
        cyc_start = 1'b1;
        @(negedge clk); cyc_start = 1'b0;
        chk({tag, " start clock"}, pin_out, first);
        @(negedge clk);
        chk({tag, " hold clock"}, pin_out, hold);
        @(negedge clk);
        chk({tag, " still held"}, pin_out, hold);
        cyc_end = 1'b1;
        @(negedge clk); cyc_end = 1'b0;
        chk({tag, " released"}, pin_out, idle);
        set_hit(0, 0, 0, 2'b00);
    endtask

    task automatic t_reset();
        chk("R1 reset oe", pin_oe, 5'b00001);
        chk("R1 reset out", pin_out, 5'b00000);
        chk("R1 reset err", {4'b0, cfg_err}, 5'b0);
    endtask

    task automatic t_ale_only();
        set_cfg(4'd0, 0, 3'd2, 0);
        set_hit(0, 1, 0, 2'b11);
        access("R2 R3 code0 ALE", 5'b00001, 5'b00001, 5'b00000, 5'b00000);
    endtask

    task automatic t_single();
        set_cfg(4'd1, 0, 3'd2, 0);
        set_hit(0, 1, 0, 2'b00);
        access("R5 R4 code1 hit", 5'b00001, 5'b00000, 5'b00000, 5'b00001);
        set_cfg(4'd4, 0, 0, 3'd5);
        set_hit(0, 0, 1, 2'b10);
        access("R5 R3 code4 hit", 5'b00011, 5'b00001, 5'b00000, 5'b00010);
    endtask

    task automatic t_dual_shared();
        set_cfg(4'd2, 0, 3'd4, 0);
        set_hit(0, 1, 0, 2'b10);
        access("R6 periph msb1", 5'b00011, 5'b00001, 5'b00001, 5'b00011);
        set_hit(0, 1, 0, 2'b01);
        access("R6 periph msb0", 5'b00011, 5'b00010, 5'b00010, 5'b00011);
        set_cfg(4'd3, 0, 0, 3'd1);
        set_hit(0, 0, 1, 2'b11);
        access("R6 mem msb1 code3", 5'b00111, 5'b00101, 5'b00100, 5'b00110);
    endtask

    task automatic t_dual_two_regions();
        set_cfg(4'd3, 0, 3'd2, 3'd6);
        set_hit(0, 0, 1, 2'b00);
        access("R7 mem->CS1", 5'b00111, 5'b00101, 5'b00100, 5'b00110);
        set_hit(0, 1, 0, 2'b11);
        access("R7 periph->CS0", 5'b00111, 5'b00011, 5'b00010, 5'b00110);
    endtask

    task automatic t_dual_code();
        set_cfg(4'd2, 3'd1, 0, 3'd3);
        set_hit(1, 0, 0, 2'b10);
        access("R8 code->CS0", 5'b00011, 5'b00010, 5'b00010, 5'b00011);
        set_hit(0, 0, 1, 2'b00);
        access("R8 mem->CS1", 5'b00011, 5'b00001, 5'b00001, 5'b00011);
        // code field 2 is not a sharing value
        set_cfg(4'd2, 3'd2, 0, 3'd3);
        set_hit(1, 0, 0, 2'b00);
        access("R10 code field 2", 5'b00011, 5'b00011, 5'b00011, 5'b00011);
    endtask

    task automatic t_quad();
        set_cfg(4'd6, 0, 3'd7, 0);
        set_hit(0, 1, 0, 2'b11);
        access("R9 code6 CS3", 5'b11111, 5'b01111, 5'b01110, 5'b11110);
        set_cfg(4'd5, 0, 0, 3'd2);
        set_hit(0, 0, 1, 2'b10);
        access("R9 code5 CS2", 5'b11011, 5'b10011, 5'b10011, 5'b11011);
        set_hit(0, 0, 1, 2'b01);
        access("R9 code5 CS1", 5'b11011, 5'b11001, 5'b11001, 5'b11011);
    endtask

    task automatic t_miss();
        set_cfg(4'd1, 0, 3'd2, 0);
        set_hit(0, 0, 1, 2'b00);
        access("R10 hit disabled region", 5'b00001, 5'b00001, 5'b00001, 5'b00001);
        set_cfg(4'd2, 0, 0, 0);
        set_hit(0, 1, 0, 2'b00);
        access("R10 no regions", 5'b00011, 5'b00011, 5'b00011, 5'b00011);
    endtask

    task automatic t_error();
        set_cfg(4'd7, 0, 3'd2, 0);
        set_hit(0, 1, 0, 2'b00);
        chk("R11 code7 oe", pin_oe, 5'b0);
        chk("R11 code7 err", {4'b0, cfg_err}, 5'b1);
        cyc_start = 1'b1;
        @(negedge clk); cyc_start = 1'b0;
        chk("R11 code7 start out", pin_out, 5'b0);
        set_cfg(4'd1, 0, 3'd2, 0);
        chk("R11 sticky err", {4'b0, cfg_err}, 5'b1);
        chk("R11 valid code oe back", pin_oe, 5'b00001);
        do_reset();
        chk("R1 reset clears err", {4'b0, cfg_err}, 5'b0);
        set_cfg(4'b1010, 0, 3'd2, 0);
        chk("R11 ext bit oe", pin_oe, 5'b0);
        chk("R11 ext bit out", pin_out, 5'b0);
        chk("R11 ext bit err", {4'b0, cfg_err}, 5'b1);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_ale_only();
        t_single();
        t_dual_shared();
        t_dual_two_regions();
        t_dual_code();
        t_quad();
        t_miss();
        t_error();
        done = 1'b1;
    end

    initial begin
        int n = 0;
        while (!done && n < 20000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule